// File: doc/BRIEF.md
# Byte-Wide Event Counter Register Port

This block is the host-facing register port of a 24-bit up/down event counter. A host with an 8-bit data bus reaches it through a chip select, a write strobe, a read strobe and a line that picks control or data. Each strobe lasts one clock cycle. A control write carries a target-select field in bits 6:5. It can reach the reset/load command register, which clears state and moves values between the internal registers. It can also reach the mode register, which picks binary or BCD counting. Data accesses go one byte at a time. A data write fills the preset register and a data read drains the output latch. One byte pointer serves both kinds of access.

The counter itself steps on single-cycle up and down pulses. It wraps in both directions and toggles carry, borrow and compare flags. A sticky error flag records up and down pulses that arrive together. The host reads the flags as a status byte on a control read.

The byte pointer is a three-state machine: `PTR_LO` (bits 7:0), `PTR_MID` (bits 15:8) and `PTR_HI` (bits 23:16). It has two transitions. The advance transition runs `PTR_LO`→`PTR_MID`→`PTR_HI`→`PTR_LO` on each data access. The rewind transition goes from any state to `PTR_LO` on a reset/load command with bit 0 set.

Top module: `evc_host_port`

## Requirements
- R1: A control write (ctl_sel=1) is decoded by bits 6:5: 00 targets the reset/load command, 01 the mode register, 10 and 11 are ignored and change no state (the byte pointer included).
- R2: The byte pointer starts at position 0 and addresses bits 7:0, 15:8 and 23:16 at positions 0, 1 and 2. Each data read or data write advances it, and it wraps from 2 to 0. A reset/load command with bit 0 = 1 returns it to 0.
- R3: A data write (ctl_sel=0) stores bus_in into the preset byte at the pointer position.
- R4: Reset/load bits 2:1: 00 no action, 01 clears the counter, 10 clears the borrow, carry, compare and sign flags, 11 clears the error flag.
- R5: The error flag sets when up_pulse and dn_pulse are both high in a cycle without a reset/load command. That cycle does not count. Only reset/load code 11 in bits 2:1 clears the flag.
- R6: Reset/load bits 4:3: 00 no action, 01 loads the preset into the counter, 10 copies the counter to the output latch, 11 copies preset bits 7:0 to the prescaler. A load takes priority over a counter clear in the same byte.
- R7: A mode write stores bit 0 as the count representation (1 = BCD, six packed digits; 0 = binary) and bits 2:1 as the count-mode field.
- R8: In binary mode a single up pulse adds 1 and a single down pulse subtracts 1. Wrapping up from 0xFFFFFF to 0 toggles carry and clears sign. Wrapping down from 0 to 0xFFFFFF toggles borrow and sets sign.
- R9: In BCD mode counting is decimal. Wrapping occurs between 999999 and 0, with the same flag effects as R8.
- R10: The compare flag toggles on every counting step whose new value equals the preset register.
- R11: While cs, rd_stb are high and wr_stb low, bus_out shows the output-latch byte at the pointer (ctl_sel=0) or the status byte {000, error, sign, compare, carry, borrow} (ctl_sel=1). Otherwise bus_out is 0.
- R12: In a cycle that carries a reset/load command, count pulses are dropped. The count does not change and the error flag is not set by them.
- R13: After reset the count, preset, output latch, prescaler, flags, mode fields and byte pointer are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rd_stb | input | 1 | Read strobe, one cycle per byte |
| ctl_sel | input | 1 | 1 = control access, 0 = data access |
| bus_in | input | 8 | Write data |
| bus_out | output | 8 | Read data |
| up_pulse | input | 1 | Count-up pulse |
| dn_pulse | input | 1 | Count-down pulse |
| count_val | output | 24 | Current count |
| flags | output | 5 | {error, sign, compare, carry, borrow} |
| prescale | output | 8 | Filter clock prescaler value |
| bcd_mode | output | 1 | Count representation (1 = BCD) |
| count_mode | output | 2 | Stored count-mode field |

## Verification
The hardest state to reach from the ports is a wrap at the top of the count range, in both binary and BCD. Stepping there by pulses would take millions of cycles. Instead, the stimulus writes a preset one step below the wrap point, three bytes through the shared pointer, and issues a load command before pulsing. The same route lets the bench check the pointer's wrap, with a fourth preset write that lands in byte 0. A load after an ignored control byte exposes any decode that wrongly rewinds the pointer.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 3;
    localparam int CNT_W   = BYTE_W * N_BYTES;
    localparam int DIGITS  = CNT_W / 4;

    typedef enum logic [1:0] {
        PTR_LO  = 2'd0,
        PTR_MID = 2'd1,
        PTR_HI  = 2'd2
    } ptr_state_t;

    typedef enum logic [1:0] {
        RC_NONE  = 2'd0,
        RC_COUNT = 2'd1,
        RC_FLAGS = 2'd2,
        RC_ERROR = 2'd3
    } rst_code_t;

    typedef enum logic [1:0] {
        XF_NONE   = 2'd0,
        XF_LOAD   = 2'd1,
        XF_LATCH  = 2'd2,
        XF_PRESCL = 2'd3
    } xfer_code_t;

    typedef struct packed {
        logic       err;
        logic       sign;
        logic       cmp;
        logic       carry;
        logic       borrow;
    } flag_t;
endpackage

// File: rtl/evc_byte_ptr.sv
module evc_byte_ptr
    import evc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       rewind_i,
    output ptr_state_t pos_o
);
    ptr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rewind_i) begin
            state_d = PTR_LO;
        end else if (step_i) begin
            unique case (state_q)
                PTR_LO:  state_d = PTR_MID;
                PTR_MID: state_d = PTR_HI;
                PTR_HI:  state_d = PTR_LO;
                default: state_d = PTR_LO;
            endcase
        end
    end

    assign pos_o = state_q;

    p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PTR_HI && step_i && !rewind_i) |=> state_q == PTR_LO);
    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !rewind_i) |=> $stable(state_q));
    p_ptr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);
endmodule

// File: rtl/evc_cmd_decode.sv
module evc_cmd_decode
    import evc_pkg::*;
(
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              ctl_i,
    input  logic [BYTE_W-1:0] din_i,
    output logic              data_wr_o,
    output logic              data_rd_o,
    output logic              stat_rd_o,
    output logic              rl_valid_o,
    output logic              mode_wr_o,
    output logic              bp_rewind_o,
    output rst_code_t         rst_code_o,
    output xfer_code_t        xfer_code_o
);
    logic wr_acc, rd_acc;

    assign wr_acc = cs_i && wr_i;
    assign rd_acc = cs_i && rd_i && !wr_i;

    always_comb begin
        data_wr_o   = wr_acc && !ctl_i;
        data_rd_o   = rd_acc && !ctl_i;
        stat_rd_o   = rd_acc && ctl_i;
        rl_valid_o  = 1'b0;
        mode_wr_o   = 1'b0;
        if (wr_acc && ctl_i) begin
            unique case (din_i[6:5])
                2'b00:   rl_valid_o = 1'b1;
                2'b01:   mode_wr_o  = 1'b1;
                default: ;
            endcase
        end
        bp_rewind_o = rl_valid_o && din_i[0];
        rst_code_o  = rl_valid_o ? rst_code_t'(din_i[2:1]) : RC_NONE;
        xfer_code_o = rl_valid_o ? xfer_code_t'(din_i[4:3]) : XF_NONE;
    end

    always_comb begin
        a_one_target_r1: assert ($countones({rl_valid_o, mode_wr_o, data_wr_o, data_rd_o, stat_rd_o}) <= 1);
    end
endmodule

// File: rtl/evc_count_core.sv
module evc_count_core
    import evc_pkg::*;
#(
    parameter int CW = evc_pkg::CNT_W
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_i,
    input  logic          dn_i,
    input  logic          hold_i,
    input  logic          bcd_i,
    input  rst_code_t     rst_code_i,
    input  logic          load_i,
    input  logic [CW-1:0] preset_i,
    output logic [CW-1:0] count_o,
    output flag_t         flags_o
);
    localparam int ND = CW / 4;
    localparam logic [CW-1:0] BIN_MAX = '1;

    logic [CW-1:0] count_q, next_val, bcd_max;
    flag_t         flags_q;
    logic          step_up, step_dn, clash, at_max, at_zero;

    function automatic logic [CW-1:0] bcd_step(input logic [CW-1:0] v, input logic up);
        logic [CW-1:0] r;
        logic          c;
        r = v;
        c = 1'b1;
        for (int i = 0; i < ND; i++) begin
            if (c) begin
                if (up) begin
                    if (v[4*i +: 4] == 4'd9) r[4*i +: 4] = 4'd0;
                    else begin r[4*i +: 4] = v[4*i +: 4] + 4'd1; c = 1'b0; end
                end else begin
                    if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
                    else begin r[4*i +: 4] = v[4*i +: 4] - 4'd1; c = 1'b0; end
                end
            end
        end
        return r;
    endfunction

    always_comb begin
        bcd_max = '0;
        for (int i = 0; i < ND; i++) bcd_max[4*i +: 4] = 4'd9;
    end

    assign step_up = up_i && !dn_i && !hold_i;
    assign step_dn = dn_i && !up_i && !hold_i;
    assign clash   = up_i && dn_i && !hold_i;
    assign at_max  = bcd_i ? (count_q == bcd_max) : (count_q == BIN_MAX);
    assign at_zero = (count_q == '0);

    always_comb begin
        next_val = count_q;
        if (step_up)      next_val = bcd_i ? bcd_step(count_q, 1'b1) : count_q + 1'b1;
        else if (step_dn) next_val = bcd_i ? bcd_step(count_q, 1'b0) : count_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= preset_i;
        end else if (rst_code_i == RC_COUNT) begin
            count_q <= '0;
        end else begin
            count_q <= next_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            if (rst_code_i == RC_FLAGS) begin
                flags_q.borrow <= 1'b0;
                flags_q.carry  <= 1'b0;
                flags_q.cmp    <= 1'b0;
                flags_q.sign   <= 1'b0;
            end else begin
                if (step_up && at_max) begin
                    flags_q.carry <= !flags_q.carry;
                    flags_q.sign  <= 1'b0;
                end
                if (step_dn && at_zero) begin
                    flags_q.borrow <= !flags_q.borrow;
                    flags_q.sign   <= 1'b1;
                end
                if ((step_up || step_dn) && next_val == preset_i)
                    flags_q.cmp <= !flags_q.cmp;
            end
            if (rst_code_i == RC_ERROR) flags_q.err <= 1'b0;
            else if (clash)             flags_q.err <= 1'b1;
        end
    end

    assign count_o = count_q;
    assign flags_o = flags_q;

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.err && rst_code_i != RC_ERROR) |=> flags_q.err);
    p_bin_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && !dn_i && !hold_i && !bcd_i) |=> count_o == $past(count_o) + 1'b1);
    p_clear_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_code_i == RC_COUNT && !load_i) |=> count_o == '0);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !load_i && rst_code_i != RC_COUNT) |=> $stable(count_o));
endmodule

// File: rtl/evc_host_port.sv
module evc_host_port
    import evc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              ctl_sel,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    input  logic              up_pulse,
    input  logic              dn_pulse,
    output logic [CNT_W-1:0]  count_val,
    output logic [4:0]        flags,
    output logic [BYTE_W-1:0] prescale,
    output logic              bcd_mode,
    output logic [1:0]        count_mode
);
    logic       data_wr, data_rd, stat_rd, rl_valid, mode_wr, bp_rewind;
    rst_code_t  rst_code;
    xfer_code_t xfer_code;
    ptr_state_t pos;
    flag_t      flag_s;

    logic [CNT_W-1:0]  preset_q, latch_q;
    logic [BYTE_W-1:0] prescale_q, latch_byte;
    logic              bcd_q;
    logic [1:0]        mode_q;

    evc_cmd_decode u_dec (
        .cs_i        (cs),
        .wr_i        (wr_stb),
        .rd_i        (rd_stb),
        .ctl_i       (ctl_sel),
        .din_i       (bus_in),
        .data_wr_o   (data_wr),
        .data_rd_o   (data_rd),
        .stat_rd_o   (stat_rd),
        .rl_valid_o  (rl_valid),
        .mode_wr_o   (mode_wr),
        .bp_rewind_o (bp_rewind),
        .rst_code_o  (rst_code),
        .xfer_code_o (xfer_code)
    );

    evc_byte_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (data_wr || data_rd),
        .rewind_i (bp_rewind),
        .pos_o    (pos)
    );

    evc_count_core #(.CW(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_i       (up_pulse),
        .dn_i       (dn_pulse),
        .hold_i     (rl_valid),
        .bcd_i      (bcd_q),
        .rst_code_i (rst_code),
        .load_i     (xfer_code == XF_LOAD),
        .preset_i   (preset_q),
        .count_o    (count_val),
        .flags_o    (flag_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q   <= '0;
            latch_q    <= '0;
            prescale_q <= '0;
            bcd_q      <= 1'b0;
            mode_q     <= 2'b00;
        end else begin
            if (data_wr) begin
                unique case (pos)
                    PTR_LO:  preset_q[7:0]   <= bus_in;
                    PTR_MID: preset_q[15:8]  <= bus_in;
                    PTR_HI:  preset_q[23:16] <= bus_in;
                    default: ;
                endcase
            end
            if (xfer_code == XF_LATCH)  latch_q    <= count_val;
            if (xfer_code == XF_PRESCL) prescale_q <= preset_q[BYTE_W-1:0];
            if (mode_wr) begin
                bcd_q  <= bus_in[0];
                mode_q <= bus_in[2:1];
            end
        end
    end

    always_comb begin
        unique case (pos)
            PTR_LO:  latch_byte = latch_q[7:0];
            PTR_MID: latch_byte = latch_q[15:8];
            PTR_HI:  latch_byte = latch_q[23:16];
            default: latch_byte = '0;
        endcase
    end

    always_comb begin
        if (data_rd)      bus_out = latch_byte;
        else if (stat_rd) bus_out = {3'b000, flag_s};
        else              bus_out = '0;
    end

    assign flags      = flag_s;
    assign prescale   = prescale_q;
    assign bcd_mode   = bcd_q;
    assign count_mode = mode_q;

    p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd_stb && !wr_stb) |-> bus_out == '0);
    p_ignored_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_stb && ctl_sel && bus_in[6]) |=> ($stable(preset_q) && $stable(bcd_q) && $stable(mode_q)));
    p_mode_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_stb && ctl_sel && bus_in[6:5] == 2'b01) |=> bcd_mode == $past(bus_in[0]));
endmodule

// File: tb/test_evc_host_port.sv
module test_evc_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 0, wr_stb = 0, rd_stb = 0, ctl_sel = 0, up_pulse = 0, dn_pulse = 0;
    logic [7:0]  bus_in = '0;
    logic [7:0]  bus_out;
    logic [23:0] count_val;
    logic [4:0]  flags;
    logic [7:0]  prescale;
    logic        bcd_mode;
    logic [1:0]  count_mode;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] rd_byte;

    // reference state
    logic [23:0] m_cnt, m_pre, m_ol;
    logic [7:0]  m_ps;
    logic        m_bcd;
    logic [1:0]  m_mode;
    logic [4:0]  m_fl;   // {err, sign, cmp, carry, borrow}
    int          m_ptr;

    always #5 clk = ~clk;

    evc_host_port i_evc_host_port (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .ctl_sel(ctl_sel), .bus_in(bus_in), .bus_out(bus_out),
        .up_pulse(up_pulse), .dn_pulse(dn_pulse), .count_val(count_val),
        .flags(flags), .prescale(prescale), .bcd_mode(bcd_mode), .count_mode(count_mode)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int to_dec(input logic [23:0] v);
        int r = 0;
        int w = 1;
        for (int i = 0; i < 6; i++) begin
            r += int'(v[4*i +: 4]) * w;
            w *= 10;
        end
        return r;
    endfunction

    function automatic logic [23:0] from_dec(input int v);
        logic [23:0] r = '0;
        int t = v;
        for (int i = 0; i < 6; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t /= 10;
        end
        return r;
    endfunction

    task automatic model_step();
        logic [23:0] o_cnt, o_pre, nv;
        logic        o_bcd, wrv, rdv, rl, cm, dw, dr, wrap;
        int          dv;
        if (!rst_n) begin
            m_cnt = '0; m_pre = '0; m_ol = '0; m_ps = '0;
            m_bcd = 0; m_mode = '0; m_fl = '0; m_ptr = 0;
            return;
        end
        o_cnt = m_cnt; o_pre = m_pre; o_bcd = m_bcd;
        wrv = cs && wr_stb;
        rdv = cs && rd_stb && !wr_stb;
        rl  = wrv && ctl_sel && bus_in[6:5] == 2'b00;
        cm  = wrv && ctl_sel && bus_in[6:5] == 2'b01;
        dw  = wrv && !ctl_sel;
        dr  = rdv && !ctl_sel;
        if (cm) begin m_bcd = bus_in[0]; m_mode = bus_in[2:1]; end
        if (dw) m_pre[8*m_ptr +: 8] = bus_in;
        if (rl && bus_in[0]) m_ptr = 0;
        else if (dw || dr)   m_ptr = (m_ptr + 1) % 3;
        if (rl) begin
            if (bus_in[4:3] == 2'd2) m_ol = o_cnt;
            if (bus_in[4:3] == 2'd3) m_ps = o_pre[7:0];
            if (bus_in[4:3] == 2'd1)      m_cnt = o_pre;
            else if (bus_in[2:1] == 2'd1) m_cnt = '0;
            if (bus_in[2:1] == 2'd2) m_fl[3:0] = '0;
            if (bus_in[2:1] == 2'd3) m_fl[4] = 1'b0;
        end else if (up_pulse ^ dn_pulse) begin
            if (o_bcd) begin
                dv   = to_dec(o_cnt);
                wrap = up_pulse ? (dv == 999999) : (dv == 0);
                dv   = up_pulse ? (dv + 1) % 1000000 : (dv + 999999) % 1000000;
                nv   = from_dec(dv);
            end else begin
                wrap = up_pulse ? (o_cnt == 24'hFFFFFF) : (o_cnt == 0);
                nv   = up_pulse ? o_cnt + 24'd1 : o_cnt - 24'd1;
            end
            if (wrap && up_pulse) begin m_fl[1] = !m_fl[1]; m_fl[3] = 1'b0; end
            if (wrap && dn_pulse) begin m_fl[0] = !m_fl[0]; m_fl[3] = 1'b1; end
            if (nv == o_pre) m_fl[2] = !m_fl[2];
            m_cnt = nv;
        end else if (up_pulse && dn_pulse) begin
            m_fl[4] = 1'b1;
        end
    endtask

    function automatic logic [7:0] model_out();
        if (cs && rd_stb && !wr_stb) return ctl_sel ? {3'b000, m_fl} : m_ol[8*m_ptr +: 8];
        return 8'h00;
    endfunction

    // per-cycle comparison against the reference model
    initial begin
        forever begin
            @(posedge clk);
            model_step();
            #1;
            chk("R8",  "count_val", 32'(count_val), 32'(m_cnt));
            chk("R4",  "flags",     32'(flags),     32'(m_fl));
            chk("R11", "bus_out",   32'(bus_out),   32'(model_out()));
            chk("R6",  "prescale",  32'(prescale),  32'(m_ps));
            chk("R7",  "mode",      32'({bcd_mode, count_mode}), 32'({m_bcd, m_mode}));
        end
    end

    task automatic cyc(input logic c, input logic w, input logic r, input logic ct,
                       input logic [7:0] d, input logic u, input logic dn);
        @(negedge clk);
        cs = c; wr_stb = w; rd_stb = r; ctl_sel = ct; bus_in = d; up_pulse = u; dn_pulse = dn;
        #1 rd_byte = bus_out;
    endtask

    task automatic ctl_wr(input logic [7:0] d); cyc(1, 1, 0, 1, d, 0, 0); endtask
    task automatic dat_wr(input logic [7:0] d); cyc(1, 1, 0, 0, d, 0, 0); endtask
    task automatic dat_rd();                    cyc(1, 0, 1, 0, 8'h00, 0, 0); endtask
    task automatic pulse(input logic u, input logic d); cyc(0, 0, 0, 0, 8'h00, u, d); endtask
    task automatic idle();                      cyc(0, 0, 0, 0, 8'h00, 0, 0); endtask

    task automatic set_preset(input logic [23:0] v);
        ctl_wr(8'h01);
        dat_wr(v[7:0]); dat_wr(v[15:8]); dat_wr(v[23:16]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13", "reset count", 32'(count_val), 0);
        chk("R13", "reset flags", 32'(flags), 0);
        rst_n = 1'b1;
        idle();
        ctl_wr(8'h20);                       // binary, normal
        set_preset(24'h123456);
        ctl_wr(8'h08); idle();
        chk("R3", "preset loaded", 32'(count_val), 32'h123456);
        pulse(1, 0); pulse(1, 0); pulse(1, 0); pulse(0, 1); idle();
        chk("R8", "binary steps", 32'(count_val), 32'h123458);
        ctl_wr(8'h11);                       // latch + rewind
        dat_rd(); chk("R2", "byte 0", 32'(rd_byte), 32'h58);
        dat_rd(); chk("R2", "byte 1", 32'(rd_byte), 32'h34);
        dat_rd(); chk("R2", "byte 2", 32'(rd_byte), 32'h12);
        dat_rd(); chk("R2", "wrap read", 32'(rd_byte), 32'h58);
        // binary wrap
        set_preset(24'hFFFFFE); ctl_wr(8'h08);
        pulse(1, 0); pulse(1, 0); idle();
        chk("R8", "up wrap", 32'({count_val, 3'b0, flags}), 32'h00000002);
        pulse(0, 1); idle();
        chk("R8", "down wrap", 32'(flags), 32'h0B);
        pulse(1, 1); idle();
        chk("R5", "clash sets error", 32'({count_val, 3'b0, flags}), 32'hFFFFFF1B);
        ctl_wr(8'h04); idle();
        chk("R5", "error survives flag clear", 32'(flags), 32'h10);
        ctl_wr(8'h06); idle();
        chk("R4", "error cleared", 32'(flags), 32'h00);
        ctl_wr(8'h02); idle();
        chk("R4", "counter cleared", 32'(count_val), 0);
        set_preset(24'hEFCDAB); ctl_wr(8'h18); idle();
        chk("R6", "prescaler", 32'(prescale), 32'hAB);
        // pointer wrap on writes
        ctl_wr(8'h01);
        dat_wr(8'h11); dat_wr(8'h22); dat_wr(8'h33); dat_wr(8'h44);
        ctl_wr(8'h08); idle();
        chk("R2", "write wrap", 32'(count_val), 32'h332244);
        ctl_wr(8'h5F);                       // select 10: ignored
        dat_wr(8'h77); ctl_wr(8'h08); idle();
        chk("R1", "ignored select", 32'(count_val), 32'h337744);
        // load wins over clear
        ctl_wr(8'h0A); idle();
        chk("R6", "load over clear", 32'(count_val), 32'h337744);
        // compare toggle
        set_preset(24'h000005); ctl_wr(8'h0C);
        pulse(1, 0); pulse(0, 1); idle();
        chk("R10", "compare toggle", 32'(flags), 32'h04);
        cyc(1, 1, 0, 1, 8'h00, 1, 0); idle();
        chk("R12", "pulse dropped", 32'(count_val), 32'h5);
        cyc(1, 1, 0, 1, 8'h00, 1, 1); idle();
        chk("R12", "clash dropped", 32'(flags), 32'h04);
        cyc(1, 0, 1, 1, 8'h00, 0, 0);
        chk("R11", "status byte", 32'(rd_byte), 32'h04);
        // BCD
        ctl_wr(8'h27); idle();
        chk("R7", "mode fields", 32'({bcd_mode, count_mode}), 32'b111);
        ctl_wr(8'h21);
        set_preset(24'h999998); ctl_wr(8'h0C);
        pulse(1, 0); idle();
        chk("R9", "bcd max", 32'(count_val), 32'h999999);
        pulse(1, 0); idle();
        chk("R9", "bcd wrap up", 32'({count_val, 3'b0, flags}), 32'h00000002);
        pulse(0, 1); idle();
        chk("R9", "bcd wrap down", 32'({count_val, 3'b0, flags}), 32'h9999990B);
        set_preset(24'h000100); ctl_wr(8'h08);
        pulse(0, 1); idle();
        chk("R9", "bcd borrow digit", 32'(count_val), 32'h000099);
        idle(); idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule